// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides when the processor core is frozen in a debug state. While frozen, the core fetches no application instructions and waits for commands from an external debugger. Five sources can request the halt:

- the debug pin held low as reset ends after a power-on;
- the same pin held low as reset ends after a debugger-forced reset;
- a decoded halt command from the serial debug link;
- a software halt instruction retired by the core;
- a breakpoint match.

A decoded resume command releases the core.

The two pin sources are not watched continuously. The pin is looked at only in the release cycle: the single cycle between the deassertion of reset and the first clock edge after it. In that cycle the halt output rises at once, so the core never fetches its first instruction. The other three sources are single-cycle strobes. They take effect at the next clock edge.

The block reports its state through a registered debug-active flag. It also gives a one-cycle entry pulse and a record of which sources caused the latest entry. There is no data stream here, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `dbg_halt_entry`

## Requirements
- R1: After any reset whose cause is 2 or 3, or whose debug pin is high, `dbg_active`, `core_halt` and `entry_pulse` are 0 and `entry_cause` is 0.
- R2: With reset cause 0 (power-on) and the pin low, `core_halt` is 1 combinationally in the release cycle. After the next clock edge, `dbg_active` is 1, `entry_pulse` is 1 and `entry_cause` is 5'b00001 (bit 0).
- R3: With reset cause 1 (debugger-forced) and the pin low, the behaviour of R2 applies, with `entry_cause` 5'b00010 (bit 1).
- R4: The pin is ignored when the reset cause is 2 or 3. It is also ignored in every cycle after the release cycle, so a low pin then yields no entry.
- R5: From the running state, `halt_cmd_stb` gives `dbg_active`=1 and `entry_pulse`=1 after the next clock edge, with `entry_cause` bit 2 set.
- R6: From the running state, `sw_halt_stb` enters as in R5, recording bit 3.
- R7: From the running state, `bkpt_hit` enters as in R5, recording bit 4.
- R8: Sources asserted together give one entry: one pulse, with `entry_cause` holding every asserted bit.
- R9: While halted, `resume_stb` alone clears `dbg_active` and `core_halt` after the next clock edge.
- R10: An entry source asserted in the same cycle as `resume_stb` wins, and the core stays halted.
- R11: While halted, entry sources produce no pulse and leave `entry_cause` unchanged.
- R12: `core_halt` is 1 whenever `dbg_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_cause | input | CAUSE_W (2) | Cause of the current reset: 0 power-on, 1 debugger-forced, 2 and 3 other causes |
| dbg_pin | input | 1 | Debug pin level; low requests a halt in the release cycle |
| halt_cmd_stb | input | 1 | Decoded halt command from the debug link, one cycle |
| sw_halt_stb | input | 1 | Software halt instruction retired, one cycle |
| bkpt_hit | input | 1 | Breakpoint match, one cycle |
| resume_stb | input | 1 | Decoded resume command, one cycle |
| core_halt | output | 1 | Holds the core suspended |
| dbg_active | output | 1 | Registered debug-state flag |
| entry_pulse | output | 1 | One-cycle pulse on each new entry |
| entry_cause | output | 5 | Sources behind the latest entry: bits 0 power-on pin, 1 forced pin, 2 command, 3 software, 4 breakpoint |

## Verification
The properties assume three things about the inputs. The strobes are known values whenever reset is off. `rst_cause` and `dbg_pin` hold steady from the start of reset through the release cycle. Nothing except a resume strobe is expected to drop the debug state.

The bench respects these assumptions. It sets `rst_cause` and the pin before it drops `rst_n`. It changes strobes only on falling clock edges, each for exactly one cycle. It changes the pin level only after the release cycle, when that level must have no effect.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int SRC_N     = 5;
  localparam int PIN_SRC_N = 2;   // bit 0: power-on pin, bit 1: forced-reset pin
  localparam int SRC_CMD   = 2;
  localparam int SRC_SWI   = 3;
  localparam int SRC_BKPT  = 4;
endpackage

// File: rtl/dbg_rst_sampler.sv
module dbg_rst_sampler #(
  parameter int CAUSE_W = 2,
  parameter int PIN_N   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               pin_lvl,
  output logic [PIN_N-1:0]   pin_req
);
  logic seen_q;
  logic release_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // Out of reset, but no clock edge has landed yet.
  assign release_cycle = rst_n & ~seen_q;

  // One request per reset cause whose code equals the bit index.
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    assign pin_req[i] = release_cycle & ~pin_lvl & (cause == CAUSE_W'(i));
  end
endmodule

// File: rtl/dbg_src_merge.sv
module dbg_src_merge #(
  parameter int N = 5
) (
  input  logic [N-1:0] src,
  input  logic         halted,
  output logic         any_req,
  output logic         new_entry
);
  logic [N-1:0] chain;

  // Ripple OR, kept explicit so each stage is visible.
  for (genvar i = 0; i < N; i++) begin : g_or
    if (i == 0) begin : g_first
      assign chain[i] = src[i];
    end else begin : g_rest
      assign chain[i] = chain[i-1] | src[i];
    end
  end

  assign any_req   = chain[N-1];
  assign new_entry = any_req & ~halted;
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         any_req,
  input  logic         new_entry,
  input  logic         resume,
  output logic         active,
  output logic         pulse,
  output logic [N-1:0] cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pulse  <= 1'b0;
      cause  <= '0;
    end else begin
      pulse <= new_entry;
      if (new_entry) cause <= src;
      // Entry outranks resume.
      if (any_req)     active <= 1'b1;
      else if (resume) active <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_halt_entry.sv
module dbg_halt_entry
  import dbg_halt_pkg::*;
#(
  parameter int CAUSE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] rst_cause,
  input  logic               dbg_pin,
  input  logic               halt_cmd_stb,
  input  logic               sw_halt_stb,
  input  logic               bkpt_hit,
  input  logic               resume_stb,
  output logic               core_halt,
  output logic               dbg_active,
  output logic               entry_pulse,
  output logic [SRC_N-1:0]   entry_cause
);
  logic [PIN_SRC_N-1:0] pin_req;
  logic [SRC_N-1:0]     src;
  logic                 any_req;
  logic                 new_entry;

  dbg_rst_sampler #(.CAUSE_W(CAUSE_W), .PIN_N(PIN_SRC_N)) u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause   (rst_cause),
    .pin_lvl (dbg_pin),
    .pin_req (pin_req)
  );

  always_comb begin
    src                  = '0;
    src[PIN_SRC_N-1:0]   = pin_req;
    src[SRC_CMD]         = halt_cmd_stb;
    src[SRC_SWI]         = sw_halt_stb;
    src[SRC_BKPT]        = bkpt_hit;
  end

  dbg_src_merge #(.N(SRC_N)) u_merge (
    .src       (src),
    .halted    (dbg_active),
    .any_req   (any_req),
    .new_entry (new_entry)
  );

  dbg_halt_fsm #(.N(SRC_N)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .any_req   (any_req),
    .new_entry (new_entry),
    .resume    (resume_stb),
    .active    (dbg_active),
    .pulse     (entry_pulse),
    .cause     (entry_cause)
  );

  // A pin request halts in the release cycle itself, before the first fetch.
  assign core_halt = dbg_active | (|pin_req);
endmodule

// File: rtl/dbg_halt_entry_chk.sv
module dbg_halt_entry_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_cmd_stb,
  input logic       sw_halt_stb,
  input logic       bkpt_hit,
  input logic       resume_stb,
  input logic       core_halt,
  input logic       dbg_active,
  input logic       entry_pulse,
  input logic [4:0] entry_cause
);
  logic stb_any;
  assign stb_any = halt_cmd_stb | sw_halt_stb | bkpt_hit;

  AST_CMD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_active && halt_cmd_stb) |=> (dbg_active && entry_pulse && entry_cause[2])); // R5
  AST_SWI_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_active && sw_halt_stb) |=> (dbg_active && entry_pulse && entry_cause[3])); // R6
  AST_BKPT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_active && bkpt_hit) |=> (dbg_active && entry_pulse && entry_cause[4])); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |=> !entry_pulse); // R8
  AST_RESUME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && resume_stb && !stb_any) |=> (!dbg_active && !core_halt)); // R9
  AST_ENTRY_BEATS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb && stb_any) |=> dbg_active); // R10
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && stb_any) |=> (!entry_pulse && $stable(entry_cause))); // R11
  AST_HALT_COVERS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |-> core_halt); // R12
endmodule

bind dbg_halt_entry dbg_halt_entry_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_cmd_stb (halt_cmd_stb),
  .sw_halt_stb  (sw_halt_stb),
  .bkpt_hit     (bkpt_hit),
  .resume_stb   (resume_stb),
  .core_halt    (core_halt),
  .dbg_active   (dbg_active),
  .entry_pulse  (entry_pulse),
  .entry_cause  (entry_cause)
);

// File: tb/tb_dbg_halt_entry.sv
`timescale 1ns/1ps
module tb_dbg_halt_entry;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rst_cause = 2'd2;
  logic       dbg_pin = 1'b1;
  logic       halt_cmd_stb = 1'b0, sw_halt_stb = 1'b0, bkpt_hit = 1'b0, resume_stb = 1'b0;
  logic       core_halt, dbg_active, entry_pulse;
  logic [4:0] entry_cause;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dbg_halt_entry dut (
    .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .dbg_pin(dbg_pin),
    .halt_cmd_stb(halt_cmd_stb), .sw_halt_stb(sw_halt_stb), .bkpt_hit(bkpt_hit),
    .resume_stb(resume_stb), .core_halt(core_halt), .dbg_active(dbg_active),
    .entry_pulse(entry_pulse), .entry_cause(entry_cause)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Reset with the given cause and pin, then check the release cycle and after.
  task automatic do_reset(input logic [1:0] cause, input logic pin);
    logic enter;
    string tag;
    enter = (pin == 1'b0) && (cause < 2'd2);
    tag = !enter ? ((pin == 1'b0) ? "R4" : "R1") : (cause == 2'd0 ? "R2" : "R3");
    @(negedge clk);
    rst_n = 1'b0; rst_cause = cause; dbg_pin = pin;
    {halt_cmd_stb, sw_halt_stb, bkpt_hit, resume_stb} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(tag, "core_halt in release cycle", 32'(core_halt), 32'(enter));
    chk(tag, "dbg_active in release cycle", 32'(dbg_active), 32'd0);
    @(negedge clk);
    chk(tag, "dbg_active after release", 32'(dbg_active), 32'(enter));
    chk(tag, "entry_pulse after release", 32'(entry_pulse), 32'(enter));
    chk(tag, "entry_cause after release", 32'(entry_cause), enter ? (32'd1 << cause) : 32'd0);
    chk("R12", "core_halt follows dbg_active", 32'(core_halt), 32'(dbg_active));
    // A low pin after the release cycle must change nothing.
    dbg_pin = 1'b0;
    @(negedge clk);
    chk("R4", "pin ignored after release: pulse", 32'(entry_pulse), 32'd0);
    chk("R4", "pin ignored after release: active", 32'(dbg_active), 32'(enter));
  endtask

  task automatic step(input logic [2:0] m, input logic r);
    halt_cmd_stb = m[0]; sw_halt_stb = m[1]; bkpt_hit = m[2]; resume_stb = r;
    @(negedge clk);
    {halt_cmd_stb, sw_halt_stb, bkpt_hit, resume_stb} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // Reset-cause and pin sweep.
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 2; p++)
        do_reset(2'(c), 1'(p));

    // Strobe sweep from both states.
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int r = 0; r < 2; r++) begin
          logic exp_act, exp_pulse;
          logic [4:0] exp_cause;
          string tag;
          do_reset(2'd2, 1'b1);
          if (s == 1) begin
            step(3'b001, 1'b0);
            chk("R5", "setup entry", 32'(dbg_active), 32'd1);
          end
          step(3'(m), 1'(r));
          exp_act   = (m != 0) ? 1'b1 : (r != 0) ? 1'b0 : 1'(s);
          exp_pulse = (m != 0) && (s == 0);
          exp_cause = exp_pulse ? 5'(m << 2) : ((s == 1) ? 5'b00100 : 5'b00000);
          if (m == 0)                 tag = (s == 1 && r == 1) ? "R9" : "R1";
          else if (s == 1 && r == 1)  tag = "R10";
          else if (s == 1)            tag = "R11";
          else if (m == 1)            tag = "R5";
          else if (m == 2)            tag = "R6";
          else if (m == 4)            tag = "R7";
          else                        tag = "R8";
          chk(tag, "dbg_active", 32'(dbg_active), 32'(exp_act));
          chk(tag, "entry_pulse", 32'(entry_pulse), 32'(exp_pulse));
          chk(tag, "entry_cause", 32'(entry_cause), 32'(exp_cause));
          chk("R12", "core_halt", 32'(core_halt), 32'(exp_act));
          @(negedge clk);
          chk("R8", "pulse lasts one cycle", 32'(entry_pulse), 32'd0);
        end
      end
    end
    finish_run();
  end
endmodule